// File: doc/BRIEF.md
# Three-wire RTC bus master

This block is a serial master for a real-time clock chip that sits behind a three-wire bus: a chip-enable line, a serial clock and a single shared data line. A local requester pulses a start strobe with a command byte, a direction flag and a data-byte count. The master raises chip enable and shifts the command out least significant bit first. It then either sends the requested number of data bytes or releases the data line and clocks the same number of bytes back in. The caller can use a single register access, a back-to-back time-register burst or a burst of up to 31 scratch bytes.

Every bus timing interval comes from a cycle-count input: chip-enable setup, chip-enable recovery, data setup, clock high and clock low. One down-counter paces each phase. Write bytes are pulled from a data input with a one-cycle "taken" pulse after each load. Read bytes come out as a byte value, a byte index and a one-cycle valid strobe, so the requester can drop them into an indexed buffer. The block drives only an output-enable for the data line; the pad tristate lives outside.

Top module: `rtc3w_master`

## Requirements
- R1: Chip enable stays high from the setup phase through the hold after the last clock. Serial clock is low in the cycle chip enable rises and in the cycle it falls.
- R2: The command byte is sent first, and every byte is shifted least significant bit first. The data line does not change while the serial clock is high.
- R3: A transaction with n data bytes produces exactly 8*(1+n) serial clock pulses.
- R4: On a read, the output-enable is high for the 8 command clocks and drops at the falling edge of the 8th clock. It stays low for all data clocks, and it is never high while chip enable is low.
- R5: On a read, each bit is sampled at the end of the clock-high phase and assembled least significant bit first. Each finished byte gives one rd_valid_o pulse with rd_idx_o counting 0, 1, 2, and so on.
- R6: The interval from chip-enable rise to the first clock rise is setup+data-setup cycles. The clock stays high for clock-high cycles, and rise to rise takes high+low+data-setup cycles. The interval from the last clock fall to chip-enable fall is low+data-setup cycles. A count of 0 acts as 1.
- R7: After chip enable falls it stays low for the recovery count before done_o pulses. No new transaction can start within that window.
- R8: A requested length of 0 moves one data byte, and a length above 31 moves 31.
- R9: busy_o is high from the cycle after an accepted start until done_o. done_o is a single-cycle pulse in the first cycle busy_o is low.
- R10: A start pulse while busy is ignored: the running transaction's command, direction and length are kept, and no new transaction follows done.
- R11: On a write, data byte k is loaded from wr_data_i when byte k-1 (or the command) completes. wr_taken_o pulses once, one cycle after each load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | start request, sampled when idle |
| rd_i | input | 1 | 1 = read data bytes, 0 = write |
| cmd_i | input | 8 | command byte |
| len_i | input | 6 | data-byte count (0 means 1, clamped to 31) |
| wr_data_i | input | 8 | next write byte |
| t_ce_setup_i | input | 12 | chip-enable setup cycles |
| t_ce_recov_i | input | 12 | chip-enable recovery cycles |
| t_data_setup_i | input | 12 | data setup / hold cycles |
| t_clk_hi_i | input | 12 | clock-high cycles |
| t_clk_lo_i | input | 12 | clock-low cycles |
| busy_o | output | 1 | transaction in progress |
| done_o | output | 1 | completion pulse |
| wr_taken_o | output | 1 | write byte consumed |
| rd_valid_o | output | 1 | read byte strobe |
| rd_idx_o | output | 5 | index of read byte |
| rd_data_o | output | 8 | read byte value |
| ce_o | output | 1 | chip enable |
| sclk_o | output | 1 | serial clock |
| sio_o | output | 1 | serial data out |
| sio_oe_o | output | 1 | serial data output-enable |
| sio_i | input | 1 | serial data in |

## Verification
The hardest condition to reach from the ports is the read turnaround. The output-enable has to drop exactly at the falling edge of the 8th command clock, and the first incoming bit, presented right after that edge, has to land in bit 0 of byte 0. The bench models the clock chip at the pins. It drives each read bit on the falling clock edge and records the output-enable at every rising edge. Timing counts are drawn at random down to 0, which makes the setup, high and low phases as short as one cycle. The length-clamp boundaries (0, 31, above 31) and a start pulse aimed at a running transaction are added as directed cases.

// File: rtl/rtc3w_pkg.sv
package rtc3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_DSU, ST_HI, ST_LO, ST_HOLD, ST_RECOV
  } rtc3w_st_e;
endpackage

// File: rtl/rtc3w_tmr.sv
module rtc3w_tmr #(
  parameter int TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] val_i,
  output logic          exp_o
);
  logic [TW-1:0] cnt_q;

  // phase lasts max(val,1) cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= (val_i == '0) ? '0 : val_i - TW'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - TW'(1);
  end

  assign exp_o = (cnt_q == '0);

  a_r6_tmr_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && exp_o) |=> exp_o);
endmodule

// File: rtl/rtc3w_shreg.sv
module rtc3w_shreg #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] ld_data_i,
  input  logic          shift_i,
  input  logic          sin_i,
  output logic [BW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= ld_data_i;
    else if (shift_i) q_o <= {sin_i, q_o[BW-1:1]};
  end

  a_r2_load_shift_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !shift_i);
endmodule

// File: rtl/rtc3w_master.sv
module rtc3w_master
  import rtc3w_pkg::*;
#(
  parameter int TW        = 12,
  parameter int LEN_W     = 6,
  parameter int MAX_BYTES = 31,
  parameter int IDX_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [7:0]       cmd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [7:0]       wr_data_i,
  input  logic [TW-1:0]    t_ce_setup_i,
  input  logic [TW-1:0]    t_ce_recov_i,
  input  logic [TW-1:0]    t_data_setup_i,
  input  logic [TW-1:0]    t_clk_hi_i,
  input  logic [TW-1:0]    t_clk_lo_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             wr_taken_o,
  output logic             rd_valid_o,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic [7:0]       rd_data_o,
  output logic             ce_o,
  output logic             sclk_o,
  output logic             sio_o,
  output logic             sio_oe_o,
  input  logic             sio_i
);
  localparam int BW    = 8;
  localparam int BIT_W = $clog2(BW);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BW - 1);

  rtc3w_st_e        st_q, st_d;
  logic             rd_q, cmd_ph_q, oe_q;
  logic [IDX_W-1:0] len_q, len_eff, byte_q;
  logic [BIT_W-1:0] bit_q;
  logic             tmr_load, tmr_exp;
  logic [TW-1:0]    tmr_val;
  logic             sh_load, sh_shift;
  logic [BW-1:0]    sh_data, sh_q;
  logic             last_byte;

  always_comb begin
    if (len_i == '0)                          len_eff = IDX_W'(1);
    else if (len_i > LEN_W'(MAX_BYTES))       len_eff = IDX_W'(MAX_BYTES);
    else                                      len_eff = len_i[IDX_W-1:0];
  end

  assign last_byte = !cmd_ph_q && (byte_q == len_q - IDX_W'(1));

  rtc3w_tmr #(.TW(TW)) u_tmr (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i(tmr_load), .val_i(tmr_val), .exp_o(tmr_exp)
  );

  rtc3w_shreg #(.BW(BW)) u_sh (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i(sh_load), .ld_data_i(sh_data),
    .shift_i(sh_shift), .sin_i(sio_i), .q_o(sh_q)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_data  = cmd_i;
    sh_shift = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_SETUP; tmr_load = 1'b1; tmr_val = t_ce_setup_i; sh_load = 1'b1;
      end
      ST_SETUP: if (tmr_exp) begin
        st_d = ST_DSU; tmr_load = 1'b1; tmr_val = t_data_setup_i;
      end
      ST_DSU: if (tmr_exp) begin
        st_d = ST_HI; tmr_load = 1'b1; tmr_val = t_clk_hi_i;
      end
      ST_HI: if (tmr_exp) begin
        st_d = ST_LO; tmr_load = 1'b1; tmr_val = t_clk_lo_i; sh_shift = 1'b1;
      end
      ST_LO: if (tmr_exp) begin
        tmr_load = 1'b1; tmr_val = t_data_setup_i;
        if (bit_q == BIT_LAST && last_byte) st_d = ST_HOLD;
        else begin
          st_d = ST_DSU;
          if (bit_q == BIT_LAST && !rd_q) begin
            sh_load = 1'b1; sh_data = wr_data_i;
          end
        end
      end
      ST_HOLD: if (tmr_exp) begin
        st_d = ST_RECOV; tmr_load = 1'b1; tmr_val = t_ce_recov_i;
      end
      ST_RECOV: if (tmr_exp) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rd_q       <= 1'b0;
      len_q      <= IDX_W'(1);
      cmd_ph_q   <= 1'b0;
      byte_q     <= '0;
      bit_q      <= '0;
      oe_q       <= 1'b0;
      done_o     <= 1'b0;
      wr_taken_o <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_idx_o   <= '0;
      rd_data_o  <= '0;
    end else begin
      st_q       <= st_d;
      done_o     <= 1'b0;
      wr_taken_o <= 1'b0;
      rd_valid_o <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          rd_q     <= rd_i;
          len_q    <= len_eff;
          cmd_ph_q <= 1'b1;
          byte_q   <= '0;
          bit_q    <= '0;
          oe_q     <= 1'b1;
        end
        ST_HI: if (tmr_exp && bit_q == BIT_LAST && rd_q) begin
          // turnaround at falling edge of last command clock
          if (cmd_ph_q) oe_q <= 1'b0;
          else begin
            rd_valid_o <= 1'b1;
            rd_data_o  <= {sio_i, sh_q[BW-1:1]};
            rd_idx_o   <= byte_q;
          end
        end
        ST_LO: if (tmr_exp) begin
          if (bit_q == BIT_LAST) begin
            bit_q <= '0;
            if (cmd_ph_q) cmd_ph_q <= 1'b0;
            else          byte_q   <= byte_q + IDX_W'(1);
            if (sh_load) wr_taken_o <= 1'b1;
          end else begin
            bit_q <= bit_q + BIT_W'(1);
          end
        end
        ST_HOLD:  if (tmr_exp) oe_q <= 1'b0;
        ST_RECOV: if (tmr_exp) done_o <= 1'b1;
        default: ;
      endcase
    end
  end

  assign ce_o     = (st_q == ST_SETUP) || (st_q == ST_DSU) || (st_q == ST_HI) ||
                    (st_q == ST_LO) || (st_q == ST_HOLD);
  assign sclk_o   = (st_q == ST_HI);
  assign sio_o    = sh_q[0];
  assign sio_oe_o = oe_q;
  assign busy_o   = (st_q != ST_IDLE);

  a_r1_sclk_low_ce_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ce_o) |-> !sclk_o);
  a_r1_sclk_low_ce_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ce_o) |-> (!sclk_o && !$past(sclk_o)));
  a_r4_oe_needs_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_o |-> !sio_oe_o);
  a_r2_sio_stable_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sio_o));
  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r5_valid_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (ce_o && !sio_oe_o));
  a_r10_dir_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_q));
  a_r8_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (len_q != '0 && len_q <= IDX_W'(MAX_BYTES)));
endmodule

// File: tb/sim_rtc3w_master.sv
`timescale 1ns/1ps
module sim_rtc3w_master;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0, rd_i = 1'b0, sio_i = 1'b0;
  logic [7:0] cmd_i = '0, wr_data_i = '0;
  logic [5:0] len_i = '0;
  logic [11:0] t_cs, t_cr, t_ds, t_hi, t_lo;
  logic busy_o, done_o, wr_taken_o, rd_valid_o, ce_o, sclk_o, sio_o, sio_oe_o;
  logic [4:0] rd_idx_o;
  logic [7:0] rd_data_o;

  always #2.5 clk_i = ~clk_i;

  rtc3w_master u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_i(rd_i), .cmd_i(cmd_i),
    .len_i(len_i), .wr_data_i(wr_data_i), .t_ce_setup_i(t_cs), .t_ce_recov_i(t_cr),
    .t_data_setup_i(t_ds), .t_clk_hi_i(t_hi), .t_clk_lo_i(t_lo), .busy_o(busy_o),
    .done_o(done_o), .wr_taken_o(wr_taken_o), .rd_valid_o(rd_valid_o),
    .rd_idx_o(rd_idx_o), .rd_data_o(rd_data_o), .ce_o(ce_o), .sclk_o(sclk_o),
    .sio_o(sio_o), .sio_oe_o(sio_oe_o), .sio_i(sio_i)
  );

  int n_chk = 0, n_err = 0;
  logic [7:0] wbytes [32];
  logic [7:0] rbytes [32];
  logic [7:0] capb [33];
  int cyc = 0, nclk, ce_rise, ce_fall, srise, sfall, done_cyc;
  int setup_meas, hold_meas, per_exp, hi_exp;
  int hi_err, per_err, oe_err, rdv_err, busy_err, r1_err, rd_cnt, wr_ptr;
  bit m_rd, m_done, p_ce, p_sclk, p_done;

  function automatic int eff(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int eff_len(input int v);
    return (v == 0) ? 1 : ((v > 31) ? 31 : v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // pin-level monitor and clock-chip model, sampled on falling clk edge
  initial begin
    forever begin
      @(negedge clk_i);
      cyc++;
      if (ce_o && !p_ce) begin
        ce_rise = cyc; nclk = 0;
        if (sclk_o) r1_err++;
      end
      if (!ce_o && p_ce) begin
        ce_fall = cyc; hold_meas = cyc - sfall;
        if (sclk_o) r1_err++;
      end
      if (sclk_o && !p_sclk) begin
        if (nclk == 0) setup_meas = cyc - ce_rise;
        else if (cyc - srise != per_exp) per_err++;
        srise = cyc;
        if (nclk / 8 < 33) capb[nclk/8][nclk%8] = sio_o;
        if (sio_oe_o != ((nclk < 8) || !m_rd)) oe_err++;
        nclk++;
      end
      if (!sclk_o && p_sclk) begin
        if (cyc - srise != hi_exp) hi_err++;
        sfall = cyc;
        if (m_rd && nclk >= 8 && (nclk - 8) / 8 < 32)
          sio_i = rbytes[(nclk-8)/8][(nclk-8)%8];
      end
      if (rd_valid_o) begin
        if (rd_cnt >= 32 || rd_data_o != rbytes[rd_cnt] || rd_idx_o != rd_cnt[4:0]) rdv_err++;
        rd_cnt++;
      end
      if (wr_taken_o) begin
        wr_ptr++;
        if (wr_ptr < 32) wr_data_i = wbytes[wr_ptr];
      end
      if (ce_o && !busy_o) busy_err++;
      if (!ce_o && sio_oe_o) oe_err++;
      if (done_o) begin
        done_cyc = cyc; m_done = 1'b1;
        if (busy_o || p_done) busy_err++;
      end
      p_ce = ce_o; p_sclk = sclk_o; p_done = done_o;
    end
  end

  task automatic run_txn(input bit rd, input logic [7:0] cmd, input int len,
                         input int ts, input int td, input int th, input int tl,
                         input int tr, input bit poke);
    int n;
    n = eff_len(len);
    t_cs = 12'(ts); t_ds = 12'(td); t_hi = 12'(th); t_lo = 12'(tl); t_cr = 12'(tr);
    for (int i = 0; i < 32; i++) begin
      wbytes[i] = 8'($urandom);
      rbytes[i] = 8'($urandom);
    end
    for (int i = 0; i < 33; i++) capb[i] = '0;
    hi_exp = eff(th); per_exp = eff(th) + eff(tl) + eff(td);
    hi_err = 0; per_err = 0; oe_err = 0; rdv_err = 0; busy_err = 0; r1_err = 0;
    rd_cnt = 0; wr_ptr = 0; m_done = 1'b0; m_rd = rd; sio_i = 1'b0;
    @(negedge clk_i);
    wr_data_i = wbytes[0];
    start_i = 1'b1; cmd_i = cmd; rd_i = rd; len_i = 6'(len);
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk_i);
      start_i = 1'b1; cmd_i = ~cmd; rd_i = !rd; len_i = 6'd3;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!m_done) @(negedge clk_i);
    @(negedge clk_i);
    chk(!busy_o && !ce_o, "R10 idle after done", int'(busy_o), 0);
    chk(capb[0] == cmd, "R2 command byte lsb first", int'(capb[0]), int'(cmd));
    chk(nclk == 8 * (1 + n), "R3/R8 clock pulse count", nclk, 8 * (1 + n));
    if (!rd) begin
      int bad = 0;
      for (int i = 0; i < n; i++) if (capb[i+1] != wbytes[i]) bad++;
      chk(bad == 0, "R2 write data bytes", bad, 0);
      chk(wr_ptr == n, "R11 write bytes taken", wr_ptr, n);
    end else begin
      chk(rd_cnt == n, "R5 read strobe count", rd_cnt, n);
      chk(rdv_err == 0, "R5 read data and index", rdv_err, 0);
      chk(wr_ptr == 0, "R11 no take on read", wr_ptr, 0);
    end
    chk(oe_err == 0, "R4 output enable", oe_err, 0);
    chk(setup_meas == eff(ts) + eff(td), "R6 ce to first clock", setup_meas, eff(ts) + eff(td));
    chk(hi_err == 0, "R6 clock high width", hi_err, 0);
    chk(per_err == 0, "R6 clock period", per_err, 0);
    chk(hold_meas == eff(tl) + eff(td), "R6 last fall to ce fall", hold_meas, eff(tl) + eff(td));
    chk(done_cyc - ce_fall == eff(tr), "R7 recovery", done_cyc - ce_fall, eff(tr));
    chk(busy_err == 0, "R9 busy and done", busy_err, 0);
    chk(r1_err == 0, "R1 clock low at ce edges", r1_err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    t_cs = 12'd1; t_cr = 12'd1; t_ds = 12'd1; t_hi = 12'd1; t_lo = 12'd1;
    repeat (3) @(negedge clk_i);
    chk(!ce_o && !sclk_o && !sio_oe_o && !busy_o && !done_o, "R9 reset state",
        int'({ce_o, sclk_o, sio_oe_o, busy_o}), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!ce_o && !busy_o, "R1 idle after reset", int'(ce_o), 0);
    run_txn(1'b0, 8'h80, 1, 3, 2, 2, 2, 3, 1'b0);   // R11 single write
    run_txn(1'b1, 8'h81, 1, 1, 1, 1, 1, 1, 1'b0);   // R5 single read
    run_txn(1'b1, 8'hBF, 7, 2, 1, 3, 2, 2, 1'b0);   // R5 time burst
    run_txn(1'b0, 8'hFE, 31, 1, 1, 1, 1, 1, 1'b0);  // R8 full burst
    run_txn(1'b1, 8'hFF, 45, 1, 2, 1, 1, 1, 1'b0);  // R8 clamp
    run_txn(1'b0, 8'hC0, 0, 2, 1, 1, 2, 2, 1'b0);   // R8 zero length
    run_txn(1'b1, 8'hC3, 2, 0, 0, 0, 0, 0, 1'b0);   // R6 zero counts
    run_txn(1'b0, 8'h8E, 3, 2, 2, 2, 2, 4, 1'b1);   // R10 start while busy
    for (int k = 0; k < 10; k++)
      run_txn(1'($urandom), 8'($urandom), int'($urandom_range(0, 40)),
              int'($urandom_range(0, 6)), int'($urandom_range(0, 4)),
              int'($urandom_range(0, 5)), int'($urandom_range(0, 5)),
              int'($urandom_range(0, 6)), 1'($urandom));
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule